// File: doc/BRIEF.md
# BCD Clock Calendar Core

This block keeps wall-clock time and calendar date in eight packed-BCD byte registers. A one-cycle pulse on `tick` advances the time by one hundredth of a second. Each field carries into the next one when it rolls over: hundredths into seconds, seconds into minutes, minutes into hours, hours into day of week and date, date into month, and month into year. The hours field runs in either 24-hour form or 12-hour form with a PM flag. The date wraps at the true length of each month, and February has 29 days in any year whose two-digit value is a multiple of four.

The control bits live inside the time registers. Hours bit 7 picks the hour format. Day bit 5 stops the counter. Day bit 4 decides whether an external reset request is passed on. One load strobe writes all eight registers in the same cycle. The snapshot output shows all eight registers at all times, with unused bits forced to zero.

Top module: `bcd_clock_core`

## Requirements
- R1: After `rst_n` is low, `snap` reads 0x00_01_01_01_00_00_00_00 (year 00, month 01, date 01, day 1, 24-hour 00:00:00.00, counter running, reset gating off).
- R2: When `load` is high at a clock edge, `snap` shows all eight bytes of `load_data` from the next cycle. Byte i is at bits 8i+7:8i. Unused bits are stored as zero: seconds and minutes bit 7, hours bit 6, day bits 7, 6 and 3, date bits 7 and 6, month bits 7 to 5.
- R3: A load in the same cycle as a tick takes the loaded value. No increment is applied on top of it.
- R4: Hundredths wrap from 99 to 00, seconds from 59 to 00 and minutes from 59 to 00. Each wrap adds one to the next field.
- R5: In 24-hour mode (hours bit 7 = 0), hours count 00 to 23. Hours bits 5:4 hold the tens digit. The wrap from 23 to 00 advances the day and the date.
- R6: In 12-hour mode (hours bit 7 = 1), hours bits 4:0 count 1 to 12 and bit 5 is PM. The step from 11 to 12 toggles PM, and the step from 12 to 01 leaves it unchanged. Only the step from 11 PM to 12 AM advances the day and the date.
- R7: Day of week (day bits 2:0) counts 1 to 7 and wraps back to 1. The bits above it are kept.
- R8: After the last date, the date returns to 01 and the month advances. The last date is 30 in months 04, 06, 09 and 11, and 31 in all other months except 02.
- R9: February ends on date 29 when the year value is a multiple of 4, and on date 28 otherwise.
- R10: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R11: While day bit 5 is 1, ticks leave every register unchanged.
- R12: `abort_req` is high exactly when `ext_rst_n` is low and day bit 4 is 0.
- R13: A cycle with neither `tick` nor `load` leaves `snap` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, 100 per second |
| load | input | 1 | Write all eight registers from `load_data` |
| load_data | input | 64 | Eight BCD bytes; byte 0 hundredths up to byte 7 year |
| ext_rst_n | input | 1 | Active-low external reset request |
| snap | output | 64 | Current register contents, same byte order as `load_data` |
| abort_req | output | 1 | Gated reset request for the access logic |

## Verification
The bench aims at the full carry ripple. One case loads 23:59:59.99 on Saturday, December 31 of year 99, because a design that stops the chain at any stage leaves a field unchanged there. For February it tries leap and non-leap years on dates 28 and 29. A wrong leap test would either skip February 29 or run on to February 30. In 12-hour mode it steps through 11 to 12 in both AM and PM and through 12 to 01. A design that toggles PM on the wrong step, or advances the date at noon, fails these cases. Random loads put masked bits into the unused positions and fire a tick together with a load, which exposes unmasked storage and increments that win over the load.

// File: rtl/bcd_clock_core.sv
module bcd_clock_core #(
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [8*NREG-1:0] load_data,
  input  logic              ext_rst_n,
  output logic [8*NREG-1:0] snap,
  output logic              abort_req
);
  localparam int W = 8 * NREG;

  function automatic logic [7:0] binc(input logic [7:0] v);
    return (v[3:0] == 4'h9) ? {v[7:4] + 4'd1, 4'h0} : v + 8'd1;
  endfunction

  logic [7:0] hs, sec, mn, hr, dy, dt, mo, yr;
  logic [7:0] hs_n, sec_n, mn_n, hr_n, dy_n, dt_n, mo_n, yr_n;
  logic [7:0] h24_inc, h12_inc, last_day;
  logic       c0, c1, c2, c3, c4, c5, c6, leap;
  logic [1:0] leap_sum;

  assign c0 = tick && !dy[5];
  assign c1 = c0 && (hs == 8'h99);
  assign c2 = c1 && (sec == 8'h59);
  assign c3 = c2 && (mn == 8'h59);

  assign hs_n  = (hs == 8'h99)  ? 8'h00 : binc(hs);
  assign sec_n = (sec == 8'h59) ? 8'h00 : binc(sec);
  assign mn_n  = (mn == 8'h59)  ? 8'h00 : binc(mn);

  assign h24_inc = binc({2'b00, hr[5:0]});
  assign h12_inc = binc({3'b000, hr[4:0]});

  always_comb begin
    if (!hr[7]) begin
      hr_n = (hr[5:0] == 6'h23) ? 8'h00 : {2'b00, h24_inc[5:0]};
      c4   = c3 && (hr[5:0] == 6'h23);
    end else begin
      if (hr[4:0] == 5'h11)      hr_n = {2'b10, ~hr[5], 5'h12};
      else if (hr[4:0] == 5'h12) hr_n = {2'b10, hr[5], 5'h01};
      else                       hr_n = {2'b10, hr[5], h12_inc[4:0]};
      c4 = c3 && (hr[4:0] == 5'h11) && hr[5];
    end
  end

  assign dy_n = {dy[7:3], (dy[2:0] == 3'd7) ? 3'd1 : dy[2:0] + 3'd1};

  assign leap_sum = {yr[4], 1'b0} + yr[1:0];
  assign leap     = (leap_sum == 2'b00);

  always_comb begin
    case (mo)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign c5   = c4 && (dt == last_day);
  assign c6   = c5 && (mo == 8'h12);
  assign dt_n = (dt == last_day) ? 8'h01 : binc(dt);
  assign mo_n = (mo == 8'h12) ? 8'h01 : binc(mo);
  assign yr_n = (yr == 8'h99) ? 8'h00 : binc(yr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs <= 8'h00; sec <= 8'h00; mn <= 8'h00; hr <= 8'h00;
      dy <= 8'h01; dt <= 8'h01; mo <= 8'h01; yr <= 8'h00;
    end else if (load) begin
      hs  <= load_data[7:0];
      sec <= load_data[15:8]  & 8'h7F;
      mn  <= load_data[23:16] & 8'h7F;
      hr  <= load_data[31:24] & 8'hBF;
      dy  <= load_data[39:32] & 8'h37;
      dt  <= load_data[47:40] & 8'h3F;
      mo  <= load_data[55:48] & 8'h1F;
      yr  <= load_data[63:56];
    end else begin
      if (c0) hs  <= hs_n;
      if (c1) sec <= sec_n;
      if (c2) mn  <= mn_n;
      if (c3) hr  <= hr_n;
      if (c4) dy  <= dy_n;
      if (c4) dt  <= dt_n;
      if (c5) mo  <= mo_n;
      if (c6) yr  <= yr_n;
    end
  end

  assign snap      = W'({yr, mo, dt, dy, hr, mn, sec, hs});
  assign abort_req = !ext_rst_n && !dy[4];
endmodule

module bcd_clock_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        load,
  input logic [63:0] load_data,
  input logic        ext_rst_n,
  input logic [63:0] snap,
  input logic        abort_req
);
  localparam logic [63:0] KEEP = 64'hFF1F3F37BF7F7FFF;

  // R2
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap & ~KEEP) == 64'd0);

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> snap == ($past(load_data) & KEEP));

  // R4
  hund_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !snap[37] && snap[7:0] == 8'h99) |=> snap[7:0] == 8'h00);

  // R11
  osc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && snap[37]) |=> $stable(snap));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(snap));

  // R12
  abort_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap[36] || ext_rst_n) |-> !abort_req);
endmodule

bind bcd_clock_core bcd_clock_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .load_data(load_data),
  .ext_rst_n(ext_rst_n), .snap(snap), .abort_req(abort_req)
);

// File: tb/test_bcd_clock_core.sv
module test_bcd_clock_core;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] KEEP = 64'hFF1F3F37BF7F7FFF;

  logic clk = 0, rst_n = 0, tick = 0, load = 0, ext_rst_n = 1;
  logic [63:0] load_data = '0;
  logic [63:0] snap;
  logic abort_req;
  logic [63:0] model;
  int checks = 0, fails = 0;
  bit done = 0;

  bcd_clock_core i_bcd_clock_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .load_data(load_data),
    .ext_rst_n(ext_rst_n), .snap(snap), .abort_req(abort_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic int month_len(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] mk(input logic [7:0] yr, mo, dt, dy, hr, mn, sc, hs);
    return {yr, mo, dt, dy, hr, mn, sc, hs};
  endfunction

  function automatic logic [63:0] step(input logic [63:0] s);
    logic [63:0] r = s;
    int v, dt, mo, yr, lim;
    logic pm;
    v = b2i(s[7:0]) + 1;   if (v < 100) begin r[7:0] = i2b(v); return r; end
    r[7:0] = 8'h00;
    v = b2i(s[15:8]) + 1;  if (v < 60) begin r[15:8] = i2b(v); return r; end
    r[15:8] = 8'h00;
    v = b2i(s[23:16]) + 1; if (v < 60) begin r[23:16] = i2b(v); return r; end
    r[23:16] = 8'h00;
    if (!s[31]) begin
      v = b2i({2'b00, s[29:24]}) + 1;
      if (v < 24) begin r[31:24] = i2b(v); return r; end
      r[31:24] = 8'h00;
    end else begin
      v = b2i({3'b000, s[28:24]});
      pm = s[29];
      if (v == 11) begin
        r[31:24] = {2'b10, ~pm, 5'h12};
        if (!pm) return r;
      end else begin
        v = (v == 12) ? 1 : v + 1;
        r[31:24] = 8'h80 | {2'b00, pm, 5'h00} | i2b(v);
        return r;
      end
    end
    r[34:32] = (s[34:32] == 3'd7) ? 3'd1 : s[34:32] + 3'd1;
    dt = b2i(s[47:40]); mo = b2i(s[55:48]); yr = b2i(s[63:56]);
    lim = month_len(mo, yr);
    if (dt < lim) begin r[47:40] = i2b(dt + 1); return r; end
    r[47:40] = 8'h01;
    if (mo < 12) begin r[55:48] = i2b(mo + 1); return r; end
    r[55:48] = 8'h01;
    r[63:56] = i2b((yr + 1) % 100);
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic ld, input logic tk, input logic [63:0] d, input string tag);
    @(negedge clk);
    load = ld; tick = tk; load_data = d;
    @(negedge clk);
    load = 0; tick = 0;
    if (ld) model = d & KEEP;
    else if (tk && !model[37]) model = step(model);
    check(tag, snap, model);
  endtask

  function automatic logic [63:0] rand_state();
    int mo, yr, dt, h, md;
    logic [7:0] hb, db;
    logic mode;
    mo = 1 + $urandom % 12;
    yr = ($urandom % 3 == 0) ? 99 : ($urandom % 25) * 4 + $urandom % 2;
    if (yr > 99) yr = 96;
    md = month_len(mo, yr);
    dt = ($urandom % 2) ? md : 1 + $urandom % md;
    mode = $urandom % 2;
    if (!mode) begin
      h = ($urandom % 2) ? 23 : $urandom % 24;
      hb = i2b(h);
    end else begin
      h = ($urandom % 2) ? 11 + $urandom % 2 : 1 + $urandom % 12;
      hb = 8'h80 | {2'b00, 1'($urandom % 2), 5'h00} | i2b(h);
    end
    db = {2'b00, 1'($urandom % 8 == 0), 1'($urandom % 2), 1'b0, 3'(($urandom % 2) ? 7 : 1 + $urandom % 7)};
    return mk(i2b(yr), i2b(mo), i2b(dt), db, hb,
              i2b(($urandom % 2) ? 59 : $urandom % 60),
              i2b(($urandom % 2) ? 59 : $urandom % 60),
              i2b(95 + $urandom % 5));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    model = 64'h0001010100000000;
    check("R1 reset value", snap, model);
    check("R12 no request after reset", {63'd0, abort_req}, 64'd0);

    cyc(1, 0, 64'h42_E3_C5_FF_F5_D9_A7_12, "R2 load with junk in unused bits");
    cyc(0, 0, 64'd0, "R13 idle hold");
    cyc(1, 0, mk(8'h10, 8'h05, 8'h14, 8'h03, 8'h00, 8'h59, 8'h59, 8'h99), "R2 load");
    cyc(0, 1, 64'd0, "R4 minute hour carry");
    if (snap[31:0] !== 32'h01000000) begin
      fails++; $display("FAIL R4: actual %h expected 01000000", snap[31:0]);
    end
    checks++;

    cyc(1, 0, mk(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59, 8'h99), "R2 load");
    cyc(0, 1, 64'd0, "R5 R7 R10 full rollover");
    check("R10 year wrap", snap, 64'h0001010100000000);

    cyc(1, 0, mk(8'h20, 8'h03, 8'h05, 8'h02, 8'h91, 8'h59, 8'h59, 8'h99), "R2 load");
    cyc(0, 1, 64'd0, "R6 11 AM to 12 PM");
    check("R6 noon no date carry", snap[47:24], 24'h0502B2);
    cyc(1, 0, mk(8'h20, 8'h03, 8'h05, 8'h02, 8'hB2, 8'h59, 8'h59, 8'h99), "R2 load");
    cyc(0, 1, 64'd0, "R6 12 PM to 1 PM");
    cyc(1, 0, mk(8'h20, 8'h03, 8'h05, 8'h02, 8'hB1, 8'h59, 8'h59, 8'h99), "R2 load");
    cyc(0, 1, 64'd0, "R6 11 PM to 12 AM");
    check("R6 midnight carry", snap[47:24], 24'h060392);

    cyc(1, 0, mk(8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99), "R2 load");
    cyc(0, 1, 64'd0, "R9 leap Feb 28");
    check("R9 leap date", snap[55:40], 16'h0229);
    cyc(0, 1, 64'd0, "R9 leap no extra tick");
    cyc(1, 0, mk(8'h24, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99), "R2 load");
    cyc(0, 1, 64'd0, "R9 leap Feb 29");
    cyc(1, 0, mk(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99), "R2 load");
    cyc(0, 1, 64'd0, "R9 common Feb 28");
    check("R9 common date", snap[55:40], 16'h0301);
    cyc(1, 0, mk(8'h23, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99), "R2 load");
    cyc(0, 1, 64'd0, "R8 30-day month");
    cyc(1, 0, mk(8'h23, 8'h01, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99), "R2 load");
    cyc(0, 1, 64'd0, "R8 31-day month");

    cyc(1, 0, mk(8'h23, 8'h01, 8'h30, 8'h21, 8'h23, 8'h59, 8'h59, 8'h99), "R2 load");
    cyc(0, 1, 64'd0, "R11 stopped");
    cyc(1, 1, mk(8'h11, 8'h06, 8'h15, 8'h04, 8'h10, 8'h20, 8'h30, 8'h99), "R3 load beats tick");

    @(negedge clk); ext_rst_n = 0; #1;
    check("R12 passed through", {63'd0, abort_req}, 64'd1);
    cyc(1, 0, mk(8'h11, 8'h06, 8'h15, 8'h14, 8'h10, 8'h20, 8'h30, 8'h99), "R2 load");
    check("R12 gated off", {63'd0, abort_req}, 64'd0);
    ext_rst_n = 1;

    for (int i = 0; i < 300; i++) begin
      logic [63:0] st = rand_state() | ({$urandom, $urandom} & ~KEEP);
      cyc(1, ($urandom % 4 == 0), st, "R2 R3 random load");
      for (int k = 0; k < 1 + int'($urandom % 6); k++)
        cyc(0, ($urandom % 5 != 0), 64'd0, "R4 R5 R6 R7 R8 R9 R10 R11 R13 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule